// File: doc/BRIEF.md
# Reset-Persistent Edge Interrupt Capture Bank

This block captures edge events on a group of asynchronous interrupt lines (eight by default) for a digital I/O card that sits on a simple byte-wide register bus. Each line is brought into the clock domain by its own synchroniser. Each line then has its own edge detector, which sets a sticky capture bit. Software reads the capture bits as one status byte. It clears chosen bits by writing a mask to a separate write-only clear register.

The capture bits are deliberately left alone by both the hardware reset and the software reset. Events that arrive around a reset are therefore never lost. The cost is that the capture bits hold no defined value at power-up, and software has to clear them before it turns on the request output.

The request output is the OR of all capture bits, gated by an enable bit. Unlike the capture bits, the enable bit is cleared by both resets.

Top module: `edge_irq_bank`

## Requirements
- R1: A low-to-high transition on input line n, held high for at least one clock period, sets bit n of the status register (read at offset 0x82, bit n = line n) no later than the third rising clock edge after the transition.
- R2: A set status bit stays 1 after its input falls again, until it is cleared. An input that stays high after its bit is cleared does not set the bit again.
- R3: A high-to-low transition, or an input held at a constant level, never sets a status bit.
- R4: A write to offset 0x84 clears every status bit whose matching data bit is 1 and leaves every bit whose matching data bit is 0 unchanged.
- R5: A read of offset 0x84 returns 0x00, whatever the state of the capture bits.
- R6: The status register is read-only: a write to offset 0x82 leaves the status unchanged.
- R7: When an edge is detected in the same cycle as a clear of the same bit, the bit ends up set.
- R8: Neither the hardware reset (rst_ni low) nor a software reset pulse (soft_rst_i high for one cycle) changes any status bit.
- R9: At power-up, before any clear, every status bit reads 1.
- R10: Bit 0 of the control register at offset 0x86 is the request enable. It can be written and read back, with the other bits of that register reading 0. It is cleared by the hardware reset and by the software reset.
- R11: irq_o is 1 exactly when the enable bit is 1 and at least one status bit is 1. It follows a clear or an enable change in the cycle after the write.
- R12: Read data is registered. rdata_o carries the value of the register addressed during a read strobe from the clock edge that samples the strobe, and holds it until the next read. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Hardware reset, asynchronous, active low |
| soft_rst_i | input | 1 | Software reset pulse, synchronous, active high |
| irq_in_i | input | CHANNELS | Asynchronous interrupt input lines |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Single rising edges on different lines show whether each line reaches its own status bit. Two lines set together and then cleared with a partial mask show whether clearing is selective. A line held high across a clear, and falling edges alone, show the difference between edge capture and level capture. A short pulse shows that narrow events are still caught. A clear write timed onto the exact cycle in which a new edge is captured shows which of the two takes priority. Hardware and software reset pulses with captured bits pending show that the capture bits survive a reset while the enable bit does not.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   // Which input transition a channel captures.
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_sel_e;

   // Register decode outcome.
   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_STATUS = 2'd1,
      REG_CLEAR  = 2'd2,
      REG_CTRL   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int                      STAGES = 2,
   parameter irq_bank_pkg::edge_sel_e EDGE   = irq_bank_pkg::EDGE_RISE
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic din_i,
   output logic edge_o
);
   import irq_bank_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              cur;

   // Synchroniser chain: stage 0 samples the asynchronous line.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign cur = chain_q[STAGES-1];

   if (EDGE == EDGE_RISE) begin : g_rise
      assign edge_o = cur & ~prev_q;
   end else if (EDGE == EDGE_FALL) begin : g_fall
      assign edge_o = ~cur & prev_q;
   end else begin : g_both
      assign edge_o = cur ^ prev_q;
   end

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
   parameter int CHANNELS = 8
) (
   input  logic                clk_i,
   input  logic [CHANNELS-1:0] edge_i,
   input  logic [CHANNELS-1:0] clr_i,
   output logic [CHANNELS-1:0] latch_o
);

   // No reset on purpose: captured events survive every reset.
   // Power-up value is undefined in silicon; modelled as all ones.
   for (genvar n = 0; n < CHANNELS; n++) begin : g_cell
      logic cell_q = 1'b1;

      // A new edge takes priority over a clear of the same bit.
      always_ff @(posedge clk_i) begin
         if (edge_i[n])
            cell_q <= 1'b1;
         else if (clr_i[n])
            cell_q <= 1'b0;
      end

      assign latch_o[n] = cell_q;
   end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
   parameter int               ADDR_W     = 8,
   parameter int               DATA_W     = 8,
   parameter int               CHANNELS   = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h82,
   parameter logic [ADDR_W-1:0] CLEAR_OFS  = 8'h84,
   parameter logic [ADDR_W-1:0] CTRL_OFS   = 8'h86
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                soft_rst_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                wr_i,
   input  logic                rd_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [CHANNELS-1:0] latch_i,
   output logic [CHANNELS-1:0] clr_o,
   output logic                en_o,
   output logic [DATA_W-1:0]   rdata_o
);
   import irq_bank_pkg::*;

   if (CHANNELS > DATA_W) begin : g_bad_width
      $error("irq_reg_port: CHANNELS must not exceed DATA_W");
   end
   if (STATUS_OFS == CLEAR_OFS || STATUS_OFS == CTRL_OFS || CLEAR_OFS == CTRL_OFS) begin : g_bad_map
      $error("irq_reg_port: register offsets must be distinct");
   end

   reg_sel_e          sel;
   logic              en_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      if (addr_i == STATUS_OFS)     sel = REG_STATUS;
      else if (addr_i == CLEAR_OFS) sel = REG_CLEAR;
      else if (addr_i == CTRL_OFS)  sel = REG_CTRL;
      else                          sel = REG_NONE;
   end

   // Clear mask: one bit per channel, 1 clears, 0 keeps.
   assign clr_o = (wr_i && sel == REG_CLEAR) ? wdata_i[CHANNELS-1:0] : '0;

   // Request enable: cleared by both resets.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         en_q <= 1'b0;
      else if (soft_rst_i)
         en_q <= 1'b0;
      else if (wr_i && sel == REG_CTRL)
         en_q <= wdata_i[0];
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         REG_STATUS: rd_mux = DATA_W'(latch_i);
         REG_CTRL:   rd_mux = DATA_W'(en_q);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         rdata_q <= '0;
      else if (rd_i)
         rdata_q <= rd_mux;
   end

   assign en_o    = en_q;
   assign rdata_o = rdata_q;

endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
   parameter int                      CHANNELS    = 8,
   parameter int                      ADDR_W      = 8,
   parameter int                      DATA_W      = 8,
   parameter int                      SYNC_STAGES = 2,
   parameter irq_bank_pkg::edge_sel_e EDGE_SEL    = irq_bank_pkg::EDGE_RISE,
   parameter logic [ADDR_W-1:0]       STATUS_OFS  = 8'h82,
   parameter logic [ADDR_W-1:0]       CLEAR_OFS   = 8'h84,
   parameter logic [ADDR_W-1:0]       CTRL_OFS    = 8'h86
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                soft_rst_i,
   input  logic [CHANNELS-1:0] irq_in_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                wr_i,
   input  logic                rd_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                irq_o
);

   if (CHANNELS < 1) begin : g_bad_channels
      $error("edge_irq_bank: CHANNELS must be at least 1");
   end

   logic [CHANNELS-1:0] edge_w;
   logic [CHANNELS-1:0] clr_w;
   logic [CHANNELS-1:0] latch_w;
   logic                en_w;

   for (genvar n = 0; n < CHANNELS; n++) begin : g_chan
      irq_sync_edge #(
         .STAGES (SYNC_STAGES),
         .EDGE   (EDGE_SEL)
      ) i_sync_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .din_i  (irq_in_i[n]),
         .edge_o (edge_w[n])
      );
   end

   irq_latch_bank #(
      .CHANNELS (CHANNELS)
   ) i_latch_bank (
      .clk_i   (clk_i),
      .edge_i  (edge_w),
      .clr_i   (clr_w),
      .latch_o (latch_w)
   );

   irq_reg_port #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CHANNELS   (CHANNELS),
      .STATUS_OFS (STATUS_OFS),
      .CLEAR_OFS  (CLEAR_OFS),
      .CTRL_OFS   (CTRL_OFS)
   ) i_reg_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .addr_i     (addr_i),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .wdata_i    (wdata_i),
      .latch_i    (latch_w),
      .clr_o      (clr_w),
      .en_o       (en_w),
      .rdata_o    (rdata_o)
   );

   assign irq_o = en_w & (|latch_w);

endmodule

// File: rtl/edge_irq_bank_chk.sv
module edge_irq_bank_chk #(
   parameter int                CHANNELS  = 8,
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CLEAR_OFS = 8'h84
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                soft_rst_i,
   input logic [ADDR_W-1:0]   addr_i,
   input logic                wr_i,
   input logic                rd_i,
   input logic [DATA_W-1:0]   rdata_o,
   input logic                irq_o,
   input logic [CHANNELS-1:0] edge_w,
   input logic [CHANNELS-1:0] latch_w
);

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((latch_w & ~$past(latch_w) & ~$past(edge_w)) == '0)); // R3

   AST_STICKY_WITHOUT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == CLEAR_OFS) |=> ((latch_w & $past(latch_w)) == $past(latch_w))); // R2

   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|edge_w) |=> ((latch_w & $past(edge_w)) == $past(edge_w))); // R7

   AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == CLEAR_OFS) |=> (rdata_o == '0)); // R5

   AST_SOFT_RESET_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst_i |=> !irq_o); // R10

   AST_IRQ_NEEDS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (|latch_w)); // R11

endmodule

bind edge_irq_bank edge_irq_bank_chk #(
   .CHANNELS  (CHANNELS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CLEAR_OFS (CLEAR_OFS)
) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .soft_rst_i (soft_rst_i),
   .addr_i     (addr_i),
   .wr_i       (wr_i),
   .rd_i       (rd_i),
   .rdata_o    (rdata_o),
   .irq_o      (irq_o),
   .edge_w     (edge_w),
   .latch_w    (latch_w)
);

// File: tb/test_edge_irq_bank.sv
`timescale 1ns/1ps
module test_edge_irq_bank;

   localparam int CH = 8;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          soft_rst_i = 1'b0;
   logic [CH-1:0] irq_in_i = '0;
   logic [7:0]    addr_i = '0;
   logic          wr_i = 1'b0;
   logic          rd_i = 1'b0;
   logic [7:0]    wdata_i = '0;
   logic [7:0]    rdata_o;
   logic          irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   edge_irq_bank i_edge_irq_bank (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .irq_in_i   (irq_in_i),
      .addr_i     (addr_i),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .irq_o      (irq_o)
   );

   // Monitor: a read strobe seen at an edge yields data checked at the next falling edge.
   initial begin
      forever begin
         @(posedge clk);
         if (rd_i) begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               checks++;
               if (rdata_o !== e) begin
                  errors++;
                  $display("FAIL %s: rdata actual 0x%02h expected 0x%02h", t, rdata_o, e);
               end
            end
         end
      end
   end

   // All tasks start and end just after a falling edge.
   task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      addr_i = a;
      rd_i   = 1'b1;
      @(negedge clk);
      rd_i   = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      addr_i  = a;
      wdata_i = d;
      wr_i    = 1'b1;
      @(negedge clk);
      wr_i    = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (irq_o !== e) begin
         errors++;
         $display("FAIL %s: irq_o actual %b expected %b", t, irq_o, e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      chk_irq(1'b0, "R10 enable cleared by hardware reset");
      rst_ni = 1'b1;
      idle(2);
      rd_chk(8'h82, 8'hFF, "R9 power-up latches read all ones (R8 reset kept them)");
      rd_chk(8'h86, 8'h00, "R10 enable reads 0 after reset");
      rd_chk(8'h84, 8'h00, "R5 clear register reads zero while latches set");
      rd_chk(8'h10, 8'h00, "R12 unmapped offset reads zero");

      // R4: clear all, status becomes zero
      wr_reg(8'h84, 8'hFF);
      rd_chk(8'h82, 8'h00, "R4 full clear");

      // R1: single rising edge on line 3
      irq_in_i[3] = 1'b1;
      idle(3);
      rd_chk(8'h82, 8'h08, "R1 rising edge on line 3");
      // R2: falls again, bit stays
      irq_in_i[3] = 1'b0;
      idle(4);
      rd_chk(8'h82, 8'h08, "R2 bit sticky after input falls");
      // R3: the falling edge added nothing; clear and hold low
      wr_reg(8'h84, 8'h08);
      idle(4);
      rd_chk(8'h82, 8'h00, "R3 falling edge does not set");

      // R2: clear while the input is held high -> no re-set
      irq_in_i[6] = 1'b1;
      idle(4);
      wr_reg(8'h84, 8'h40);
      idle(4);
      rd_chk(8'h82, 8'h00, "R2 held-high level does not re-set after clear");
      irq_in_i[6] = 1'b0;
      idle(4);
      rd_chk(8'h82, 8'h00, "R3 falling edge of line 6 does not set");

      // R4: selective clear
      irq_in_i[0] = 1'b1;
      irq_in_i[5] = 1'b1;
      idle(4);
      irq_in_i[0] = 1'b0;
      irq_in_i[5] = 1'b0;
      idle(3);
      rd_chk(8'h82, 8'h21, "R1 lines 0 and 5 captured together");
      wr_reg(8'h84, 8'h00);
      rd_chk(8'h82, 8'h21, "R4 zero mask leaves bits");
      rd_chk(8'h84, 8'h00, "R5 clear register reads zero");
      wr_reg(8'h82, 8'h00);
      rd_chk(8'h82, 8'h21, "R6 write to status ignored");
      wr_reg(8'h84, 8'h01);
      rd_chk(8'h82, 8'h20, "R4 partial mask clears only bit 0");

      // R11: request output
      wr_reg(8'h86, 8'h01);
      chk_irq(1'b1, "R11 enable with pending bit");
      rd_chk(8'h86, 8'h01, "R10 enable reads back");
      wr_reg(8'h84, 8'h20);
      chk_irq(1'b0, "R11 no pending bits");

      // R1: short pulse (two clocks)
      irq_in_i[7] = 1'b1;
      idle(2);
      irq_in_i[7] = 1'b0;
      idle(1);
      chk_irq(1'b1, "R11 request rises after short pulse captured");
      rd_chk(8'h82, 8'h80, "R1 short pulse captured");

      // R8: soft and hard reset keep latches
      soft_rst_i = 1'b1;
      idle(1);
      soft_rst_i = 1'b0;
      chk_irq(1'b0, "R10 soft reset clears enable");
      rd_chk(8'h82, 8'h80, "R8 soft reset keeps latch");
      rst_ni = 1'b0;
      idle(2);
      rst_ni = 1'b1;
      idle(1);
      rd_chk(8'h82, 8'h80, "R8 hard reset keeps latch");
      rd_chk(8'h86, 8'h00, "R10 hard reset clears enable");

      // R7: clear lands in the cycle the new edge is captured
      irq_in_i[2] = 1'b1;
      idle(4);
      irq_in_i[2] = 1'b0;
      idle(4);
      rd_chk(8'h82, 8'h84, "R1 line 2 captured");
      irq_in_i[2] = 1'b1;
      idle(2);
      wr_reg(8'h84, 8'h04);
      rd_chk(8'h82, 8'h84, "R7 edge wins over simultaneous clear");
      irq_in_i[2] = 1'b0;
      wr_reg(8'h84, 8'hFF);
      idle(3);
      rd_chk(8'h82, 8'h00, "R4 final clear");

      idle(3);
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R12: reads left unanswered actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule